// File: doc/BRIEF.md
# Interleaved Multi-Channel Sliding DFT

This block computes a running discrete Fourier transform over one sample stream that carries several time-multiplexed channels. After a clear, sample number i belongs to channel i mod K. K is the channel count, chosen at run time and bounded by a build-time maximum. Every accepted sample updates the N-bin spectrum of its own channel with the single-step recursive update. The refreshed bins come out at once, tagged with channel and bin number, so nothing waits for a whole frame to be gathered and reordered.

Only one adder/rotator datapath exists. Each channel's state lives in copies that the current channel number selects: N complex bin accumulators and an N-deep history of its own samples. A control unit walks the N bins of the active channel one per clock. It holds off the next sample until that walk is done. It also tracks how many samples each channel has received since the last clear, so that outputs from a window that is not yet full are flagged.

A clear input, or any change on the channel-count input, empties every accumulator and history. It also restarts the channel rotation, so every channel's recursion starts from a known zero state.

Top module: `sdft_interleaved`

## Requirements
- R1: After a clear, the j-th accepted sample (counting from 0) is applied to channel j mod K. Its outputs carry that value on `outChan`.
- R2: After channel c accepts a sample, bin k of c is sum over d=0..N-1 of x_c[n-d]*W^(k*(d+1)). Here W=exp(+j*2*pi/N), x_c[n] is the newest sample of c, and samples before the last clear count as zero. With the default N=4 the twiddles are exactly 1, j, -1, -j, so the result is exact.
- R3: Each accepted sample (`inValid` and `inReady` both high at a rising edge) yields exactly N outputs on consecutive clocks. The first is visible after the next rising edge. `outBin` runs 0,1,..,N-1 and `outChan` is the same on all N. `outValid` is low at all other times, including after reset.
- R4: `inReady` is low from the accepting edge until N rising edges later. Two accepted samples are therefore at least N clocks apart.
- R5: `outPriming` is 1 on the outputs of a channel's first N-1 samples since the last clear, and 0 from its N-th sample onward.
- R6: While `clear` is high, `inReady` is low. The clear edge zeroes all state, aborts any bin walk in progress, and leaves `outValid` low on the following cycle.
- R7: Any change of `numCh` acts as a clear in the cycle it is seen: `inReady` goes low and the rotation, priming counts and spectra restart.
- R8: `numCh`=0 behaves as K=1. Values above MAXCH behave as K=MAXCH.
- R9: Accumulators are DW+log2(N)+1 bits wide, so full-scale inputs (every sample -2^(DW-1), or alternating extremes) give exact, unwrapped bin values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart of all channel state |
| numCh | input | $clog2(MAXCH+1) | Run-time channel count K |
| inValid | input | 1 | Sample strobe |
| inSample | input | DW | Signed input sample |
| inReady | output | 1 | Block can take a sample this cycle |
| outValid | output | 1 | Bin output strobe |
| outChan | output | $clog2(MAXCH) | Channel of the bin output |
| outBin | output | $clog2(N) | Bin number of the output |
| outRe | output | DW+$clog2(N)+1 | Signed real part of the bin |
| outIm | output | DW+$clog2(N)+1 | Signed imaginary part of the bin |
| outPriming | output | 1 | The channel's window is not yet full |

## Verification
Pseudo-random streams are driven at each channel count from 1 to the maximum. Every bin is compared with a direct windowed sum, which separates correct per-channel routing from histories that mix between channels or stale accumulator copies. The clamped counts 0 and 7 test the mapping of out-of-range settings. Constant and alternating full-scale inputs push bins 0 and N/2 to their largest magnitudes and expose any lack of guard bits. A clear in the middle of a bin walk, followed by fresh samples, confirms that the walk is aborted and that the recursion restarts from zero on channel 0 with priming raised.

// File: rtl/sdft_pkg.sv
package sdft_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic clr;      // wipe all channel state
    logic load;     // take inSample into the selected channel history
    logic binEn;    // update one bin this cycle
    logic priming;  // the active channel window is still filling
  } sdftStrobes_t;

  // Quantised twiddle, part selects cosine (0) or sine (1) of 2*pi*k/n.
  function automatic int twiddleQ(int k, int n, int fw, bit sinePart);
    real ang;
    real v;
    ang = 6.283185307179586 * real'(k) / real'(n);
    v = (sinePart ? $sin(ang) : $cos(ang)) * (2.0 ** fw);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

endpackage

// File: rtl/sdft_ctrl.sv
module sdft_ctrl #(
  parameter int N = 4,
  parameter int MAXCH = 4,
  localparam int LOGN = $clog2(N),
  localparam int CW = $clog2(MAXCH + 1),
  localparam int CHW = $clog2(MAXCH),
  localparam int PCW = $clog2(N + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clear,
  input  logic [CW-1:0]           numCh,
  input  logic                    inValid,
  output logic                    inReady,
  output sdft_pkg::sdftStrobes_t  st,
  output logic [CHW-1:0]          loadChan,
  output logic [CHW-1:0]          actChan,
  output logic [LOGN-1:0]         actBin
);

  logic [CW-1:0]  lastK;
  logic [CW-1:0]  effK;
  logic [CHW-1:0] lastCh;
  logic [CHW-1:0] nextChan;
  logic           busy;
  logic           actPriming;
  logic [PCW-1:0] primeCnt [MAXCH];
  logic           doClr;
  logic           accept;

  // R8: clamp the requested channel count into 1..MAXCH
  always_comb begin
    if (numCh == '0)                effK = CW'(1);
    else if (numCh > CW'(MAXCH))    effK = CW'(MAXCH);
    else                            effK = numCh;
  end

  assign lastCh  = CHW'(effK - CW'(1));
  assign doClr   = clear || (numCh != lastK);   // R6, R7
  assign inReady = !busy && !doClr;
  assign accept  = inValid && inReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastK      <= '0;
      busy       <= 1'b0;
      nextChan   <= '0;
      actChan    <= '0;
      actBin     <= '0;
      actPriming <= 1'b1;
      for (int c = 0; c < MAXCH; c++) primeCnt[c] <= '0;
    end else begin
      lastK <= numCh;
      if (doClr) begin
        busy     <= 1'b0;
        nextChan <= '0;
        actBin   <= '0;
        for (int c = 0; c < MAXCH; c++) primeCnt[c] <= '0;
      end else if (accept) begin
        busy       <= 1'b1;
        actBin     <= '0;
        actChan    <= nextChan;
        nextChan   <= (nextChan == lastCh) ? '0 : nextChan + 1'b1;   // R1
        actPriming <= primeCnt[nextChan] < PCW'(N - 1);               // R5
        if (primeCnt[nextChan] < PCW'(N))
          primeCnt[nextChan] <= primeCnt[nextChan] + 1'b1;
      end else if (busy) begin
        actBin <= actBin + 1'b1;
        if (actBin == LOGN'(N - 1)) busy <= 1'b0;                     // R4
      end
    end
  end

  assign loadChan   = nextChan;
  assign st.clr     = doClr;
  assign st.load    = accept;
  assign st.binEn   = busy && !doClr;
  assign st.priming = actPriming;

endmodule

// File: rtl/sdft_datapath.sv
module sdft_datapath #(
  parameter int N = 4,
  parameter int MAXCH = 4,
  parameter int DW = 8,
  parameter int FW = 14,
  localparam int LOGN = $clog2(N),
  localparam int CHW = $clog2(MAXCH),
  localparam int AW = DW + LOGN + 1,
  localparam int SW = AW + 1,
  localparam int TW = FW + 2,
  localparam int PW = SW + TW + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  sdft_pkg::sdftStrobes_t  st,
  input  logic [CHW-1:0]          loadChan,
  input  logic [CHW-1:0]          actChan,
  input  logic [LOGN-1:0]         actBin,
  input  logic signed [DW-1:0]    inSample,
  output logic                    outValid,
  output logic [CHW-1:0]          outChan,
  output logic [LOGN-1:0]         outBin,
  output logic signed [AW-1:0]    outRe,
  output logic signed [AW-1:0]    outIm,
  output logic                    outPriming
);

  localparam logic signed [PW-1:0] RND = PW'(1) <<< (FW - 1);

  // Twiddle ROM, W^k = cos + j sin of 2*pi*k/N
  logic signed [TW-1:0] twRe [N];
  logic signed [TW-1:0] twIm [N];
  for (genvar k = 0; k < N; k++) begin : g_tw
    localparam int CV = sdft_pkg::twiddleQ(k, N, FW, 1'b0);
    localparam int SV = sdft_pkg::twiddleQ(k, N, FW, 1'b1);
    assign twRe[k] = TW'(CV);
    assign twIm[k] = TW'(SV);
  end

  // Per-channel state copies
  logic signed [AW-1:0] accRe [MAXCH][N];
  logic signed [AW-1:0] accIm [MAXCH][N];
  logic signed [DW-1:0] hist  [MAXCH][N];
  logic [LOGN-1:0]      wrPtr [MAXCH];
  logic signed [DW-1:0] xNew;
  logic signed [DW-1:0] xOld;

  // Shared arithmetic: add newest, drop oldest, rotate by W^k, round
  logic signed [SW-1:0] sumRe, sumIm;
  logic signed [TW-1:0] cRe, cIm;
  logic signed [PW-1:0] pRe, pIm, rRe, rIm;
  logic signed [AW-1:0] newRe, newIm;

  always_comb begin
    sumRe = SW'(accRe[actChan][actBin]) + SW'(xNew) - SW'(xOld);
    sumIm = SW'(accIm[actChan][actBin]);
    cRe   = twRe[actBin];
    cIm   = twIm[actBin];
    pRe   = PW'(sumRe) * PW'(cRe) - PW'(sumIm) * PW'(cIm);
    pIm   = PW'(sumRe) * PW'(cIm) + PW'(sumIm) * PW'(cRe);
    rRe   = (pRe + RND) >>> FW;
    rIm   = (pIm + RND) >>> FW;
    newRe = rRe[AW-1:0];
    newIm = rIm[AW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < MAXCH; c++) begin
        wrPtr[c] <= '0;
        for (int b = 0; b < N; b++) begin
          accRe[c][b] <= '0;
          accIm[c][b] <= '0;
          hist[c][b]  <= '0;
        end
      end
      xNew       <= '0;
      xOld       <= '0;
      outValid   <= 1'b0;
      outChan    <= '0;
      outBin     <= '0;
      outRe      <= '0;
      outIm      <= '0;
      outPriming <= 1'b1;
    end else if (st.clr) begin
      for (int c = 0; c < MAXCH; c++) begin
        wrPtr[c] <= '0;
        for (int b = 0; b < N; b++) begin
          accRe[c][b] <= '0;
          accIm[c][b] <= '0;
          hist[c][b]  <= '0;
        end
      end
      outValid <= 1'b0;
    end else begin
      outValid <= st.binEn;
      if (st.load) begin
        xNew                            <= inSample;
        xOld                            <= hist[loadChan][wrPtr[loadChan]];
        hist[loadChan][wrPtr[loadChan]] <= inSample;
        wrPtr[loadChan]                 <= wrPtr[loadChan] + 1'b1;
      end
      if (st.binEn) begin
        accRe[actChan][actBin] <= newRe;
        accIm[actChan][actBin] <= newIm;
        outRe      <= newRe;
        outIm      <= newIm;
        outChan    <= actChan;
        outBin     <= actBin;
        outPriming <= st.priming;
      end
    end
  end

endmodule

// File: rtl/sdft_interleaved.sv
module sdft_interleaved #(
  parameter int N = 4,
  parameter int MAXCH = 4,
  parameter int DW = 8,
  parameter int FW = 14,
  localparam int LOGN = $clog2(N),
  localparam int CW = $clog2(MAXCH + 1),
  localparam int CHW = $clog2(MAXCH),
  localparam int AW = DW + LOGN + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clear,
  input  logic [CW-1:0]        numCh,
  input  logic                 inValid,
  input  logic signed [DW-1:0] inSample,
  output logic                 inReady,
  output logic                 outValid,
  output logic [CHW-1:0]       outChan,
  output logic [LOGN-1:0]      outBin,
  output logic signed [AW-1:0] outRe,
  output logic signed [AW-1:0] outIm,
  output logic                 outPriming
);

  sdft_pkg::sdftStrobes_t st;
  logic [CHW-1:0]  loadChan;
  logic [CHW-1:0]  actChan;
  logic [LOGN-1:0] actBin;

  sdft_ctrl #(.N(N), .MAXCH(MAXCH)) u_ctrl (
    .clk(clk), .rstN(rstN), .clear(clear), .numCh(numCh),
    .inValid(inValid), .inReady(inReady), .st(st),
    .loadChan(loadChan), .actChan(actChan), .actBin(actBin)
  );

  sdft_datapath #(.N(N), .MAXCH(MAXCH), .DW(DW), .FW(FW)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .loadChan(loadChan),
    .actChan(actChan), .actBin(actBin), .inSample(inSample),
    .outValid(outValid), .outChan(outChan), .outBin(outBin),
    .outRe(outRe), .outIm(outIm), .outPriming(outPriming)
  );

endmodule

// File: rtl/sdft_interleaved_chk.sv
module sdft_interleaved_chk #(
  parameter int N = 4,
  parameter int MAXCH = 4,
  localparam int LOGN = $clog2(N),
  localparam int CW = $clog2(MAXCH + 1),
  localparam int CHW = $clog2(MAXCH),
  localparam int GW = $clog2(N + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            clear,
  input logic [CW-1:0]   numCh,
  input logic            inValid,
  input logic            inReady,
  input logic            outValid,
  input logic [CHW-1:0]  outChan,
  input logic [LOGN-1:0] outBin,
  input logic            outPriming
);

  logic [CW-1:0]       lastK;
  logic [GW-1:0]       sinceAcc;
  logic [2**CHW-1:0]   steady;
  logic                accepted;
  logic                kChg;
  logic                anyClr;

  assign accepted = inValid && inReady;
  assign kChg     = numCh != lastK;
  assign anyClr   = clear || kChg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastK    <= '0;
      sinceAcc <= GW'(N);
      steady   <= '0;
    end else begin
      lastK <= numCh;
      if (anyClr) begin
        sinceAcc <= GW'(N);
        steady   <= '0;
      end else begin
        if (accepted)                sinceAcc <= GW'(1);
        else if (sinceAcc < GW'(N))  sinceAcc <= sinceAcc + 1'b1;
        if (outValid && !outPriming) steady[outChan] <= 1'b1;
      end
    end
  end

  AST_BIN_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(outValid) && ($past(outBin) != LOGN'(N - 1))
      |-> (outBin == $past(outBin) + 1'b1) && (outChan == $past(outChan))); // R3

  AST_ACCEPT_GAP: assert property (@(posedge clk) disable iff (!rstN)
    accepted |-> sinceAcc >= GW'(N)); // R4

  AST_PRIMING_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    outValid && steady[outChan] |-> !outPriming); // R5

  AST_CLEAR_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    clear |-> !inReady); // R6

  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    anyClr |=> !outValid); // R6

  AST_KCHG_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    kChg |-> !inReady); // R7

endmodule

bind sdft_interleaved sdft_interleaved_chk #(.N(N), .MAXCH(MAXCH)) u_chk (
  .clk(clk), .rstN(rstN), .clear(clear), .numCh(numCh),
  .inValid(inValid), .inReady(inReady), .outValid(outValid),
  .outChan(outChan), .outBin(outBin), .outPriming(outPriming)
);

// File: tb/sdft_interleaved_tb.sv
module sdft_interleaved_tb;

  localparam int N = 4;
  localparam int MAXCH = 4;
  localparam int DW = 8;
  localparam int CW = 3;
  localparam int AW = 11;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 clear = 1'b0;
  logic [CW-1:0]        numCh = 3'd1;
  logic                 inValid = 1'b0;
  logic signed [DW-1:0] inSample = '0;
  logic                 inReady;
  logic                 outValid;
  logic [1:0]           outChan;
  logic [1:0]           outBin;
  logic signed [AW-1:0] outRe;
  logic signed [AW-1:0] outIm;
  logic                 outPriming;

  int checks = 0;
  int errors = 0;
  int kEff = 1;
  int rot = 0;
  int hist [MAXCH][N];
  int cnt [MAXCH];
  int seed = 32'h1234_5678;

  always #10 clk = ~clk;

  sdft_interleaved u_dut (
    .clk(clk), .rstN(rstN), .clear(clear), .numCh(numCh),
    .inValid(inValid), .inSample(inSample), .inReady(inReady),
    .outValid(outValid), .outChan(outChan), .outBin(outBin),
    .outRe(outRe), .outIm(outIm), .outPriming(outPriming)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic modelClear();
    rot = 0;
    for (int c = 0; c < MAXCH; c++) begin
      cnt[c] = 0;
      for (int d = 0; d < N; d++) hist[c][d] = 0;
    end
  endtask

  // R7 / R8: change the channel count, model the implied clear
  task automatic setK(input int v);
    bit changed;
    changed = (numCh != CW'(v));
    numCh = CW'(v);
    kEff = (v == 0) ? 1 : ((v > MAXCH) ? MAXCH : v);
    #1;
    if (changed) chk(inReady == 1'b0, "R7", "inReady while count changes", int'(inReady), 0);
    @(posedge clk); @(negedge clk);
    modelClear();
  endtask

  function automatic int nextRand();
    seed = seed * 1103515245 + 12345;
    return int'($signed(seed[23:16]));
  endfunction

  // Send one sample and check all N bin outputs against the windowed sum.
  task automatic sendSample(input int x);
    int ch, er, ei, p, v;
    int w = 0;
    while (!inReady && w < 40) begin
      @(posedge clk); @(negedge clk); w++;
    end
    chk(inReady == 1'b1, "R4", "inReady before send", int'(inReady), 1);
    inValid = 1'b1;
    inSample = DW'(x);
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    chk(inReady == 1'b0, "R4", "inReady right after accept", int'(inReady), 0);
    ch = rot;
    rot = (rot + 1) % kEff;
    for (int d = N - 1; d > 0; d--) hist[ch][d] = hist[ch][d-1];
    hist[ch][0] = x;
    cnt[ch]++;
    for (int b = 0; b < N; b++) begin
      @(posedge clk); @(negedge clk);
      er = 0; ei = 0;
      for (int d = 0; d < N; d++) begin
        v = hist[ch][d];
        p = (b * (d + 1)) % 4;
        case (p)
          0: er += v;
          1: ei += v;
          2: er -= v;
          default: ei -= v;
        endcase
      end
      chk(outValid == 1'b1, "R3", "outValid in bin walk", int'(outValid), 1);
      chk(int'(outBin) == b, "R3", "bin order", int'(outBin), b);
      chk(int'(outChan) == ch, "R1", "channel tag", int'(outChan), ch);
      chk(int'(outRe) == er, "R2", "real part", int'(outRe), er);
      chk(int'(outIm) == ei, "R2", "imag part", int'(outIm), ei);
      chk(outPriming == (cnt[ch] < N), "R5", "priming flag", int'(outPriming), int'(cnt[ch] < N));
      chk(inReady == (b == N - 1), "R4", "inReady during walk", int'(inReady), int'(b == N - 1));
    end
    @(posedge clk); @(negedge clk);
    chk(outValid == 1'b0, "R3", "outValid after walk", int'(outValid), 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R3", "outValid in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(outValid == 1'b0, "R3", "outValid after reset", int'(outValid), 0);
    chk(inReady == 1'b1, "R4", "inReady after reset", int'(inReady), 1);

    // R1, R2, R5, R7: sweep every legal channel count with random data
    for (int k = 1; k <= MAXCH; k++) begin
      setK(k);
      for (int i = 0; i < N * k + 3; i++) sendSample(nextRand());
    end

    // R8: out-of-range counts
    setK(0);
    for (int i = 0; i < 6; i++) sendSample(nextRand());
    setK(7);
    for (int i = 0; i < 18; i++) sendSample(nextRand());

    // R6: clear in the middle of a bin walk
    setK(2);
    for (int i = 0; i < 3; i++) sendSample(nextRand());
    inValid = 1'b1; inSample = 8'sd55;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(outValid == 1'b1, "R3", "walk started", int'(outValid), 1);
    clear = 1'b1;
    #1 chk(inReady == 1'b0, "R6", "inReady while clear", int'(inReady), 0);
    @(posedge clk); @(negedge clk);
    clear = 1'b0;
    chk(outValid == 1'b0, "R6", "outValid after clear", int'(outValid), 0);
    modelClear();
    for (int i = 0; i < 10; i++) sendSample(nextRand());

    // R9: full-scale constant and alternating extremes
    setK(1);
    for (int i = 0; i < 6; i++) sendSample(-128);
    for (int i = 0; i < 6; i++) sendSample((i % 2 == 0) ? 127 : -128);
    for (int i = 0; i < 6; i++) sendSample((i % 2 == 0) ? -128 : 127);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule